// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a cache and the next level of memory. The cache hands it outgoing writes: write-through stores, or dirty lines pushed out on replacement. The buffer holds them in a small queue, so the cache never waits for the slower memory to finish a write. A single memory request port is shared between two kinds of traffic. One is a read-miss fetch. The other is draining the oldest queued write.

When the cache presents a read miss, the read address is compared in one cycle against every occupied queue slot. A write being enqueued in the same cycle is compared as well. If nothing matches, the read takes the memory port ahead of all queued writes. If one or more entries match, the data of the youngest matching write is returned straight from the buffer, and memory is not touched. The eviction-then-fetch case is supported directly. The displaced line is enqueued in the same cycle the miss read is accepted. The fetch then goes out first, and the displaced line drains after the read has returned.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset the buffer is empty: `wr_ready` and `rd_ready` are 1, and `mem_req_valid` and `rd_resp_valid` are 0.
- R2: `wr_ready` is 0 exactly when DEPTH writes are held. A write offered while `wr_ready` is 0 is dropped: it never reaches memory.
- R3: Queued writes leave on the memory port in arrival order, one per cycle in which `mem_req_valid`, `mem_req_ready` and `mem_req_write`=1 are all high. A write is only offered when the buffer is not empty, no read is in flight, and `rd_valid` is low.
- R4: A read whose address matches no queued write issues a memory request with `mem_req_write`=0. This request comes before any queued write. The read's data, taken from `mem_rsp_data`, appears on `rd_resp_data` in the cycle after `mem_rsp_valid`.
- R5: A read whose address matches a queued write issues no memory read. `rd_resp_valid` rises in the cycle right after acceptance. `rd_resp_data` carries the data of the youngest matching write.
- R6: A write and a read accepted in the same cycle are ordered write first. The read forwards that write's data if the addresses are equal. Otherwise the read is issued to memory before the new write drains.
- R7: From acceptance of a read that goes to memory until its response, `rd_ready` is 0 and no write is offered on the memory port.
- R8: Several queued writes to one address reach memory in their arrival order, so the last one wins.
- R9: Every accepted read produces exactly one single-cycle `rd_resp_valid` pulse. At most one read is unanswered at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Cache offers a write |
| wr_ready | output | 1 | Buffer can take a write this cycle |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_valid | input | 1 | Cache presents a read miss |
| rd_ready | output | 1 | Buffer can take a read this cycle |
| rd_addr | input | AW | Read address |
| rd_resp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rd_resp_data | output | DW | Read data, forwarded or fetched |
| mem_req_valid | output | 1 | Request offered to memory |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Write data of the request |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DW | Memory read data |

## Verification
The bench targets the following cases:
- Duplicate addresses inside a full queue. A design that forwarded the oldest match would return stale data. One that coalesced or reordered writes would leave the wrong final value in memory.
- A miss read arriving while writes are pending and memory is stalled. The memory log must show the read before every write. A design that drained first would show writes ahead of it.
- A write and a read presented in the same cycle. A design that compared only against stored entries would miss the forward.
- A swept mix of hits, misses, stalls and overflow attempts, checked against a program-order shadow memory. This catches any lost, duplicated or stale value.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    // Read-side sequencing: idle, fetch request offered, fetch data awaited
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_ISSUE = 2'd1,
        RD_WAIT  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/wbuf_store.sv
// Circular queue of pending writes; exposes all slots oldest first.
module wbuf_store #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             push,
    input  logic [AW-1:0]                    push_addr,
    input  logic [DW-1:0]                    push_data,
    input  logic                             pop,
    output logic [DEPTH-1:0][AW-1:0]         ord_addr,
    output logic [DEPTH-1:0][DW-1:0]         ord_data,
    output logic [DEPTH-1:0]                 ord_live,
    output logic [$clog2(DEPTH+1)-1:0]       count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [PTR_W-1:0]         head;
        logic [CNT_W-1:0]         count;
    } store_t;

    store_t s_d, s_q;

    function automatic logic [PTR_W-1:0] wrap(input int v);
        int w;
        w = (v >= DEPTH) ? v - DEPTH : v;
        return w[PTR_W-1:0];
    endfunction

    always_comb begin
        logic [PTR_W-1:0] tail;
        s_d  = s_q;
        tail = wrap(int'(s_q.head) + int'(s_q.count));
        if (push) begin
            s_d.addr[tail] = push_addr;
            s_d.data[tail] = push_data;
        end
        if (pop) begin
            s_d.head = wrap(int'(s_q.head) + 1);
        end
        s_d.count = s_q.count + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_order
        assign ord_addr[k] = s_q.addr[wrap(int'(s_q.head) + k)];
        assign ord_data[k] = s_q.data[wrap(int'(s_q.head) + k)];
        assign ord_live[k] = CNT_W'(k) < s_q.count;
    end

    assign count = s_q.count;
endmodule

// File: rtl/wbuf_match.sv
// Parallel compare of a read address against queued and incoming writes.
// Younger entries override older ones; the incoming write is youngest.
module wbuf_match #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0][AW-1:0] ord_addr,
    input  logic [DEPTH-1:0][DW-1:0] ord_data,
    input  logic [DEPTH-1:0]         ord_live,
    input  logic                     in_valid,
    input  logic [AW-1:0]            in_addr,
    input  logic [DW-1:0]            in_data,
    input  logic [AW-1:0]            look_addr,
    output logic                     hit,
    output logic [DW-1:0]            hit_data
);
    logic [DEPTH-1:0] eq;

    for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
        assign eq[k] = ord_live[k] && (ord_addr[k] == look_addr);
    end

    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (eq[k]) begin
                hit      = 1'b1;
                hit_data = ord_data[k];
            end
        end
        if (in_valid && (in_addr == look_addr)) begin
            hit      = 1'b1;
            hit_data = in_data;
        end
    end
endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass
    import wbuf_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_valid,
    output logic          rd_ready,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_resp_valid,
    output logic [DW-1:0] rd_resp_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data
);
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        rd_state_e     st;
        logic [AW-1:0] rd_addr;
        logic          rsp_valid;
        logic [DW-1:0] rsp_data;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [DEPTH-1:0][AW-1:0] ord_addr;
    logic [DEPTH-1:0][DW-1:0] ord_data;
    logic [DEPTH-1:0]         ord_live;
    logic [CNT_W-1:0]         count;
    logic                     push, pop, rd_take, drain_en;
    logic                     hit;
    logic [DW-1:0]            hit_data;

    wbuf_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (wr_addr),
        .push_data (wr_data),
        .pop       (pop),
        .ord_addr  (ord_addr),
        .ord_data  (ord_data),
        .ord_live  (ord_live),
        .count     (count)
    );

    wbuf_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_match (
        .ord_addr  (ord_addr),
        .ord_data  (ord_data),
        .ord_live  (ord_live),
        .in_valid  (push),
        .in_addr   (wr_addr),
        .in_data   (wr_data),
        .look_addr (rd_addr),
        .hit       (hit),
        .hit_data  (hit_data)
    );

    // Handshakes and memory-port arbitration: a pending read always wins.
    always_comb begin
        wr_ready      = (count != CNT_W'(DEPTH));
        push          = wr_valid && wr_ready;
        rd_ready      = (c_q.st == RD_IDLE);
        rd_take       = rd_valid && rd_ready;
        drain_en      = (c_q.st == RD_IDLE) && !rd_valid && (count != '0);
        mem_req_valid = (c_q.st == RD_ISSUE) || drain_en;
        mem_req_write = (c_q.st != RD_ISSUE);
        mem_req_addr  = (c_q.st == RD_ISSUE) ? c_q.rd_addr : ord_addr[0];
        mem_req_wdata = ord_data[0];
        pop           = drain_en && mem_req_ready;
    end

    always_comb begin
        c_d           = c_q;
        c_d.rsp_valid = 1'b0;
        unique case (c_q.st)
            RD_IDLE: begin
                if (rd_take) begin
                    if (hit) begin
                        c_d.rsp_valid = 1'b1;
                        c_d.rsp_data  = hit_data;
                    end else begin
                        c_d.st      = RD_ISSUE;
                        c_d.rd_addr = rd_addr;
                    end
                end
            end
            RD_ISSUE: begin
                if (mem_req_ready) c_d.st = RD_WAIT;
            end
            RD_WAIT: begin
                if (mem_rsp_valid) begin
                    c_d.st        = RD_IDLE;
                    c_d.rsp_valid = 1'b1;
                    c_d.rsp_data  = mem_rsp_data;
                end
            end
            default: c_d.st = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= RD_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_resp_valid = c_q.rsp_valid;
    assign rd_resp_data  = c_q.rsp_data;
endmodule

// File: rtl/wbuf_bypass_chk.sv
module wbuf_bypass_chk #(
    parameter int DEPTH = 4
) (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic wr_ready,
    input logic rd_valid,
    input logic rd_ready,
    input logic rd_resp_valid,
    input logic mem_req_valid,
    input logic mem_req_ready,
    input logic mem_req_write
);
    int occ_q;
    int open_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q  <= 0;
            open_q <= 0;
        end else begin
            occ_q  <= occ_q + int'(wr_valid && wr_ready)
                            - int'(mem_req_valid && mem_req_ready && mem_req_write);
            open_q <= open_q + int'(rd_valid && rd_ready) - int'(rd_resp_valid);
        end
    end

    p_ready_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready == (occ_q != DEPTH));
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= DEPTH);
    p_empty_no_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == 0) |-> !(mem_req_valid && mem_req_write));
    p_read_in_flight_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write) |-> !rd_ready);
    p_hold_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ready |-> !(mem_req_valid && mem_req_write));
    p_resp_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_resp_valid |-> (open_q == 1));
    p_single_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q <= 1) && (open_q >= 0));
endmodule

bind wbuf_bypass wbuf_bypass_chk #(.DEPTH(DEPTH)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .rd_valid      (rd_valid),
    .rd_ready      (rd_ready),
    .rd_resp_valid (rd_resp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write)
);

// File: tb/test_wbuf_bypass.sv
module test_wbuf_bypass;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int DEPTH = 4;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0, rd_valid = 1'b0, mem_ready = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready, rd_ready, rd_resp_valid;
    logic [DW-1:0] rd_resp_data;
    logic          mem_req_valid, mem_req_write, mem_rsp_valid;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata, mem_rsp_data;

    int checks = 0, failures = 0;

    logic [DW-1:0] mem   [256];
    logic [DW-1:0] shadow[256];
    logic          log_wr  [256];
    logic [AW-1:0] log_addr[256];
    logic [DW-1:0] log_data[256];
    int            log_n = 0;
    logic          pend = 1'b0;
    int            tmr = 0;
    logic [DW-1:0] rsp_buf = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbuf_bypass #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_wbuf_bypass (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // Memory model: in-order, fixed read latency, logs every accepted request
    assign mem_rsp_valid = pend && (tmr == 0);
    assign mem_rsp_data  = rsp_buf;

    always @(posedge clk) begin
        if (mem_req_valid && mem_ready) begin
            if (log_n < 256) begin
                log_wr[log_n]   <= mem_req_write;
                log_addr[log_n] <= mem_req_addr;
                log_data[log_n] <= mem_req_wdata;
            end
            log_n <= log_n + 1;
            if (mem_req_write) mem[mem_req_addr] <= mem_req_wdata;
            else begin
                pend    <= 1'b1;
                tmr     <= LAT - 1;
                rsp_buf <= mem[mem_req_addr];
            end
        end else if (mem_rsp_valid) begin
            pend <= 1'b0;
        end else if (pend) begin
            tmr <= tmr - 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic enqueue(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int waited = 0;
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        forever begin
            logic ok;
            ok = wr_ready;
            @(negedge clk);
            if (ok) break;
            waited++;
            if (waited > 2) mem_ready = 1'b1;
        end
        wr_valid = 1'b0;
        shadow[a] = d;
    endtask

    // Returns read data and the number of cycles from accept to response
    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output int lat);
        @(negedge clk);
        while (!rd_ready) @(negedge clk);
        rd_valid = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_valid = 1'b0;
        lat = 1;
        while (!rd_resp_valid) begin @(negedge clk); lat++; end
        d = rd_resp_data;
    endtask

    task automatic read_check(input string req, input logic [AW-1:0] a);
        logic [DW-1:0] d; int lat;
        do_read(a, d, lat);
        check(req, d, shadow[a]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DW-1:0] d; int lat; int base; int rseen;
        for (int a = 0; a < 256; a++) begin
            mem[a] = DW'(a * 3 + 1);
            shadow[a] = DW'(a * 3 + 1);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 wr_ready", wr_ready, 1);
        check("R1 rd_ready", rd_ready, 1);
        check("R1 mem_req_valid", mem_req_valid, 0);
        check("R1 rd_resp_valid", rd_resp_valid, 0);

        // R2/R3/R8: fill with memory stalled, try overflow, then drain
        mem_ready = 1'b0;
        base = log_n;
        enqueue(8'h10, 16'hA001);
        enqueue(8'h20, 16'hA002);
        enqueue(8'h10, 16'hA003);
        enqueue(8'h30, 16'hA004);
        check("R2 wr_ready low when full", wr_ready, 0);
        wr_valid = 1'b1; wr_addr = 8'h50; wr_data = 16'hDEAD;
        repeat (2) @(negedge clk);
        wr_valid = 1'b0;
        check("R2 stays full", wr_ready, 0);
        mem_ready = 1'b1;
        repeat (12) @(negedge clk);
        check("R2 dropped write absent", log_n - base, 4);
        check("R2 drop left memory", mem[8'h50], 16'h50 * 3 + 1);
        check("R3 order 0", {log_wr[base], log_addr[base], log_data[base]}, {1'b1, 8'h10, 16'hA001});
        check("R3 order 1", {log_wr[base+1], log_addr[base+1], log_data[base+1]}, {1'b1, 8'h20, 16'hA002});
        check("R8 order 2", {log_wr[base+2], log_addr[base+2], log_data[base+2]}, {1'b1, 8'h10, 16'hA003});
        check("R3 order 3", {log_wr[base+3], log_addr[base+3], log_data[base+3]}, {1'b1, 8'h30, 16'hA004});
        check("R8 last wins", mem[8'h10], 16'hA003);
        check("R2 ready after drain", wr_ready, 1);

        // R5: forwarding with memory stalled; youngest duplicate wins
        mem_ready = 1'b0;
        base = log_n;
        enqueue(8'h60, 16'hB001);
        enqueue(8'h61, 16'hB002);
        enqueue(8'h60, 16'hB003);
        enqueue(8'h62, 16'hB004);
        do_read(8'h60, d, lat);
        check("R5 youngest match data", d, 16'hB003);
        check("R5 one-cycle latency", lat, 1);
        do_read(8'h61, d, lat);
        check("R5 forward data", d, 16'hB002);
        do_read(8'h62, d, lat);
        check("R5 forward newest slot", d, 16'hB004);
        check("R5 no memory access", log_n - base, 0);

        // R4/R7: miss read bypasses four queued writes
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = 8'h55; mem_ready = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        while (!rd_resp_valid) @(negedge clk);
        check("R4 miss data", rd_resp_data, 16'h55 * 3 + 1);
        check("R7 no drain during fetch", log_n - base, 1);
        check("R4 read goes first", {log_wr[base], log_addr[base]}, {1'b0, 8'h55});
        repeat (10) @(negedge clk);
        check("R3 writes drain after read", log_n - base, 5);
        check("R3 first write after read", log_addr[base+1], 8'h60);

        // R6: same-cycle eviction and fetch
        mem_ready = 1'b0;
        base = log_n;
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 8'h40; wr_data = 16'hC001;
        rd_valid = 1'b1; rd_addr = 8'h41;
        @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0; shadow[8'h40] = 16'hC001;
        mem_ready = 1'b1;
        while (!rd_resp_valid) @(negedge clk);
        check("R6 fetch data", rd_resp_data, shadow[8'h41]);
        repeat (6) @(negedge clk);
        check("R6 read before eviction", {log_wr[base], log_addr[base], log_wr[base+1], log_addr[base+1]},
              {1'b0, 8'h41, 1'b1, 8'h40});
        mem_ready = 1'b0;
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 8'h42; wr_data = 16'hC002;
        rd_valid = 1'b1; rd_addr = 8'h42;
        @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0; shadow[8'h42] = 16'hC002;
        check("R6 same-cycle forward valid", rd_resp_valid, 1);
        check("R6 same-cycle forward data", rd_resp_data, 16'hC002);
        mem_ready = 1'b1;
        repeat (6) @(negedge clk);

        // R9 sweep: mixed hits, misses and stalls against the shadow memory
        rseen = 0;
        for (int i = 0; i < 48; i++) begin
            mem_ready = (i % 3 != 0);
            enqueue(AW'(8'h80 + (i * 5) % 8), DW'(16'h1000 + i * 37));
            if (i % 2 == 1) begin
                mem_ready = (i % 4 != 1);
                if (!mem_ready) begin
                    // only reads known to hit may run with memory stalled
                    mem_ready = 1'b1;
                end
                do_read(AW'(8'h80 + (i * 3) % 8), d, lat);
                check("R9 sweep read", d, shadow[8'h80 + (i * 3) % 8]);
                @(negedge clk);
                check("R9 single pulse", rd_resp_valid, 0);
                rseen++;
            end
        end
        mem_ready = 1'b1;
        repeat (20) @(negedge clk);
        for (int a = 8'h80; a < 8'h88; a++) begin
            check("R8 final memory", mem[a], shadow[a]);
        end
        check("R9 reads answered", rseen, 24);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule